// File: doc/BRIEF.md
# Lockstep Shift-Stack Register File

This block is a sixteen-entry processor register file in which every windowed register sits on top of its own hardware shift stack. All stacks move together. A call-time push copies each current value one level deeper and leaves the top as it was, so values already there can serve as arguments to the callee. A return-time pop lifts every stack one level, which restores the caller's set. Registers 0 to 5 and the stack pointer (index 14) are plain global registers with no stack. Indices 6 to 13 and 15 are stacked. A separate return-address stack is loaded from `call_addr` on every completed push, and its top is always visible on `ret_addr`.

A depth counter records how many levels hold live data. The counter runs from 1 to `LEVELS`. A push at full depth raises an overflow trap and does not complete. A pop at depth 1 raises an underflow trap and does not complete. A trap handler outside the block uses the spill and fill operations to move the deepest live level to memory and back, then retries the request. A return mask chooses, per stacked register, which tops keep their current value through a pop, so a callee can hand several results back.

Top module: `psrf_regfile`

## Requirements
- R1: After synchronous reset, `depth` is 1, every register reads 0, `ret_addr` is 0 and both trap outputs are low.
- R2: Global registers (indices 0 to 5 and 14) hold their written value across pushes and pops.
- R3: A push with `depth` below `LEVELS` completes and raises `depth` by 1. Every stacked top keeps its value, and the old value is saved one level below. Starting from depth 1, `LEVELS`-1 consecutive pushes complete without overflow.
- R4: A push at `depth`==`LEVELS` drives `ovf_trap` high in the same cycle and is ignored: depth and all register contents stay unchanged.
- R5: A completed pop lowers `depth` by 1 and restores each unmasked stacked register to the value it had before the matching push.
- R6: A pop at `depth`==1, with no push requested, drives `unf_trap` high in the same cycle and is ignored.
- R7: Return-mask bit k covers stacked slot k. Slots 0 to 7 are registers 6 to 13, and slot 8 is register 15. When bit k is set, that register keeps its top value through a pop instead of taking the level below.
- R8: A completed push loads `call_addr` into the top of the return-address stack, so `ret_addr` equals it after the edge. A pop restores the previous return address.
- R9: `spill_data` always shows level `depth`-1 of every stack. Slot k sits at bits [k*DATA_W +: DATA_W], and the return-address stack is slot 9. A spill request at `depth` above 1 lowers `depth` by 1.
- R10: A fill request at `depth` below `LEVELS` writes `fill_data` into level `depth` of every stack, using the same slot layout, and raises `depth` by 1.
- R11: A register write in the same cycle as a push lands in the new top. The value the register had before the edge is saved one level below.
- R12: Requests are served by priority: push first, then pop, then spill, then fill. Lower-priority requests in the same cycle are ignored. A spill at depth 1 and a fill at full depth are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | DATA_W | Read port A data (current top) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | DATA_W | Register write data |
| push_req | input | 1 | Save the current set (call) |
| pop_req | input | 1 | Restore the caller's set (return) |
| call_addr | input | DATA_W | Return address pushed on a completed push |
| ret_addr | output | DATA_W | Top of the return-address stack |
| rmask_we | input | 1 | Load the return mask |
| rmask_data | input | 9 | Return-mask value, one bit per stacked slot |
| spill_req | input | 1 | Retire the deepest live level |
| fill_req | input | 1 | Refill one level below the deepest live level |
| fill_data | input | 10*DATA_W | Refill values, one slot per stack |
| spill_data | output | 10*DATA_W | Deepest live level, one slot per stack |
| depth | output | DEP_W | Number of live levels, 1 to LEVELS |
| ovf_trap | output | 1 | Push refused at full depth |
| unf_trap | output | 1 | Pop refused at depth 1 |

## Verification
Two pairs of functions can fall in the same cycle and need a defined outcome: a register write with a push, and a spill with a fill. The first pair is provoked by writing register 6 on each of three pushes. The bench then confirms that the top shows the new value and that, after the levels fill up, `spill_data` exposes the value register 6 held before the first push. The second pair is provoked by raising spill and fill together at depth 3. The outcome is judged by `depth` falling to 2, and a later lone fill is seen arriving through `spill_data`. Push together with pop at depth 1 is judged the same way: `depth` must reach 2 with no underflow trap.

// File: rtl/psrf_pkg.sv
package psrf_pkg;

    localparam int unsigned REG_COUNT     = 16;
    localparam int unsigned IDX_W         = 4;
    localparam int unsigned GLOBAL_LAST   = 5;
    localparam int unsigned SP_INDEX      = 14;
    localparam int unsigned STACKED_COUNT = 9;
    localparam int unsigned RA_SLOT       = STACKED_COUNT;
    localparam int unsigned SLOT_COUNT    = STACKED_COUNT + 1;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_SPILL,
        OP_FILL
    } stack_op_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } trap_s;

    function automatic logic reg_is_stacked(input int unsigned idx);
        return (idx > GLOBAL_LAST) && (idx != SP_INDEX);
    endfunction

    function automatic int unsigned slot_of(input int unsigned idx);
        int unsigned n;
        n = 0;
        for (int unsigned i = 0; i < idx; i++) begin
            if (reg_is_stacked(i)) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/psrf_depth_ctrl.sv
module psrf_depth_ctrl
    import psrf_pkg::*;
#(
    parameter int unsigned LEVELS = 4,
    parameter int unsigned DEP_W  = $clog2(LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             spill_req,
    input  logic             fill_req,
    output stack_op_e        op,
    output trap_s            trap,
    output logic [DEP_W-1:0] depth
);

    localparam logic [DEP_W-1:0] FULL = DEP_W'(LEVELS);
    localparam logic [DEP_W-1:0] ONE  = DEP_W'(1);

    logic [DEP_W-1:0] depth_q;

    always_comb begin
        trap.ovf = push_req && (depth_q == FULL);
        trap.unf = pop_req && !push_req && (depth_q == ONE);
        op = OP_NONE;
        if (push_req) begin
            if (!trap.ovf) op = OP_PUSH;
        end else if (pop_req) begin
            if (!trap.unf) op = OP_POP;
        end else if (spill_req) begin
            if (depth_q > ONE) op = OP_SPILL;
        end else if (fill_req) begin
            if (depth_q < FULL) op = OP_FILL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= ONE;
        end else begin
            case (op)
                OP_PUSH, OP_FILL: depth_q <= depth_q + ONE;
                OP_POP, OP_SPILL: depth_q <= depth_q - ONE;
                default:          depth_q <= depth_q;
            endcase
        end
    end

    assign depth = depth_q;

    assert_depth_range_R3: assert property (@(posedge clk) disable iff (rst)
        (depth_q >= ONE) && (depth_q <= FULL));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        trap.ovf |=> $stable(depth_q));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        trap.unf |=> $stable(depth_q));

    assert_push_grows_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_PUSH) |=> (depth_q == $past(depth_q) + ONE));

    assert_spill_shrinks_R9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SPILL) |=> (depth_q == $past(depth_q) - ONE));

endmodule

// File: rtl/psrf_shift_stack.sv
module psrf_shift_stack #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LEVELS = 4,
    parameter int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic              keep_top,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_en,
    input  logic [LVL_W-1:0]  fill_lvl,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [LVL_W-1:0]  peek_lvl,
    output logic [DATA_W-1:0] top_q,
    output logic [DATA_W-1:0] peek_q
);

    logic [DATA_W-1:0] lvl_q [LEVELS];
    logic [DATA_W-1:0] lvl_d [LEVELS];

    always_comb begin
        lvl_d = lvl_q;
        if (push) begin
            for (int i = 1; i < int'(LEVELS); i++) lvl_d[i] = lvl_q[i-1];
        end else if (pop) begin
            for (int i = 0; i < int'(LEVELS) - 1; i++) lvl_d[i] = lvl_q[i+1];
            lvl_d[LEVELS-1] = '0;
            if (keep_top) lvl_d[0] = lvl_q[0];
        end else if (fill_en) begin
            lvl_d[fill_lvl] = fill_data;
        end
        if (wr_en) lvl_d[0] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(LEVELS); i++) lvl_q[i] <= '0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign top_q  = lvl_q[0];
    assign peek_q = lvl_q[peek_lvl];

    assert_push_keeps_top_R3: assert property (@(posedge clk) disable iff (rst)
        (push && !wr_en) |=> $stable(top_q));

    assert_push_saves_below_R11: assert property (@(posedge clk) disable iff (rst)
        push |=> (lvl_q[1] == $past(lvl_q[0])));

    assert_mask_holds_top_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && keep_top && !wr_en) |=> $stable(top_q));

    assert_pop_restores_R5: assert property (@(posedge clk) disable iff (rst)
        (pop && !keep_top && !wr_en) |=> (top_q == $past(lvl_q[1])));

endmodule

// File: rtl/psrf_flat_reg.sv
module psrf_flat_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wr_data;
    end

endmodule

// File: rtl/psrf_regfile.sv
module psrf_regfile
    import psrf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LEVELS = 4,
    parameter int unsigned DEP_W  = $clog2(LEVELS + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [IDX_W-1:0]               rd_a_idx,
    output logic [DATA_W-1:0]              rd_a_data,
    input  logic [IDX_W-1:0]               rd_b_idx,
    output logic [DATA_W-1:0]              rd_b_data,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           push_req,
    input  logic                           pop_req,
    input  logic [DATA_W-1:0]              call_addr,
    output logic [DATA_W-1:0]              ret_addr,
    input  logic                           rmask_we,
    input  logic [STACKED_COUNT-1:0]       rmask_data,
    input  logic                           spill_req,
    input  logic                           fill_req,
    input  logic [SLOT_COUNT*DATA_W-1:0]   fill_data,
    output logic [SLOT_COUNT*DATA_W-1:0]   spill_data,
    output logic [DEP_W-1:0]               depth,
    output logic                           ovf_trap,
    output logic                           unf_trap
);

    localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    stack_op_e                op;
    trap_s                    trap;
    logic [DEP_W-1:0]         depth_w;
    logic                     do_push, do_pop, do_fill;
    logic [LVL_W-1:0]         peek_lvl, fill_lvl;
    logic [STACKED_COUNT-1:0] rmask_q;
    logic [DATA_W-1:0]        reg_val [REG_COUNT];

    psrf_depth_ctrl #(.LEVELS(LEVELS), .DEP_W(DEP_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .spill_req (spill_req),
        .fill_req  (fill_req),
        .op        (op),
        .trap      (trap),
        .depth     (depth_w)
    );

    assign do_push  = (op == OP_PUSH);
    assign do_pop   = (op == OP_POP);
    assign do_fill  = (op == OP_FILL);
    assign peek_lvl = LVL_W'(depth_w - DEP_W'(1));
    assign fill_lvl = LVL_W'(depth_w);

    always_ff @(posedge clk) begin
        if (rst)           rmask_q <= '0;
        else if (rmask_we) rmask_q <= rmask_data;
    end

    for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
        if (reg_is_stacked(r)) begin : g_stk
            localparam int unsigned SLOT = slot_of(r);
            psrf_shift_stack #(.DATA_W(DATA_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_stk (
                .clk       (clk),
                .rst       (rst),
                .push      (do_push),
                .pop       (do_pop),
                .keep_top  (rmask_q[SLOT]),
                .wr_en     (wr_en && (wr_idx == IDX_W'(r))),
                .wr_data   (wr_data),
                .fill_en   (do_fill),
                .fill_lvl  (fill_lvl),
                .fill_data (fill_data[SLOT*DATA_W +: DATA_W]),
                .peek_lvl  (peek_lvl),
                .top_q     (reg_val[r]),
                .peek_q    (spill_data[SLOT*DATA_W +: DATA_W])
            );
        end else begin : g_glb
            psrf_flat_reg #(.DATA_W(DATA_W)) u_glb (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_en && (wr_idx == IDX_W'(r))),
                .wr_data (wr_data),
                .q       (reg_val[r])
            );
        end
    end

    psrf_shift_stack #(.DATA_W(DATA_W), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_ra_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .pop       (do_pop),
        .keep_top  (1'b0),
        .wr_en     (do_push),
        .wr_data   (call_addr),
        .fill_en   (do_fill),
        .fill_lvl  (fill_lvl),
        .fill_data (fill_data[RA_SLOT*DATA_W +: DATA_W]),
        .peek_lvl  (peek_lvl),
        .top_q     (ret_addr),
        .peek_q    (spill_data[RA_SLOT*DATA_W +: DATA_W])
    );

    assign rd_a_data = reg_val[rd_a_idx];
    assign rd_b_data = reg_val[rd_b_idx];
    assign depth     = depth_w;
    assign ovf_trap  = trap.ovf;
    assign unf_trap  = trap.unf;

    assert_traps_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ovf_trap, unf_trap}));

    assert_ret_addr_load_R8: assert property (@(posedge clk) disable iff (rst)
        do_push |=> (ret_addr == $past(call_addr)));

    assert_sp_ignores_stack_R2: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_idx == IDX_W'(SP_INDEX))) |=> $stable(reg_val[SP_INDEX]));

endmodule

// File: tb/psrf_regfile_tb.sv
module psrf_regfile_tb;
    import psrf_pkg::*;

    localparam int unsigned W  = 32;
    localparam int unsigned LV = 4;
    localparam int unsigned DW = $clog2(LV + 1);

    logic clk = 1'b0;
    logic rst;
    logic [3:0] rd_a_idx, rd_b_idx, wr_idx;
    logic [W-1:0] rd_a_data, rd_b_data, wr_data, call_addr, ret_addr;
    logic wr_en, push_req, pop_req, rmask_we, spill_req, fill_req;
    logic [STACKED_COUNT-1:0] rmask_data;
    logic [SLOT_COUNT*W-1:0] fill_data, spill_data;
    logic [DW-1:0] depth;
    logic ovf_trap, unf_trap;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    psrf_regfile #(.DATA_W(W), .LEVELS(LV)) u_dut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .push_req(push_req), .pop_req(pop_req),
        .call_addr(call_addr), .ret_addr(ret_addr),
        .rmask_we(rmask_we), .rmask_data(rmask_data),
        .spill_req(spill_req), .fill_req(fill_req),
        .fill_data(fill_data), .spill_data(spill_data),
        .depth(depth), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; push_req = 0; pop_req = 0; rmask_we = 0;
        spill_req = 0; fill_req = 0;
    endtask

    task automatic step();
        @(posedge clk); #1; idle();
    endtask

    task automatic rd(input int idx, output logic [W-1:0] v);
        rd_a_idx = 4'(idx); #1; v = rd_a_data;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        check("R1 depth", W'(depth), 1);
        rd(6, v); check("R1 r6", v, 0);
        rd(0, v); check("R1 r0", v, 0);
        check("R1 ret", ret_addr, 0);
        check("R1 traps", W'({ovf_trap, unf_trap}), 0);
    endtask

    task automatic t_globals();
        logic [W-1:0] v;
        wr_en = 1; wr_idx = 3; wr_data = 32'h33; step();
        wr_en = 1; wr_idx = 14; wr_data = 32'h1414; step();
        push_req = 1; call_addr = 32'h100; step();
        check("R2 depth after push", W'(depth), 2);
        rd(3, v); check("R2 r3 after push", v, 32'h33);
        rd(14, v); check("R2 sp after push", v, 32'h1414);
        pop_req = 1; step();
        rd(3, v); check("R2 r3 after pop", v, 32'h33);
        rd_b_idx = 14; #1; check("R2 sp after pop", rd_b_data, 32'h1414);
    endtask

    task automatic t_push_pop();
        logic [W-1:0] v;
        wr_en = 1; wr_idx = 6; wr_data = 32'h66; step();
        push_req = 1; call_addr = 32'h200; step();
        rd(6, v); check("R3 r6 kept on push", v, 32'h66);
        check("R8 ret after push", ret_addr, 32'h200);
        wr_en = 1; wr_idx = 6; wr_data = 32'h77; step();
        pop_req = 1; step();
        rd(6, v); check("R5 r6 restored", v, 32'h66);
        check("R5 depth", W'(depth), 1);
        check("R8 ret after pop", ret_addr, 0);
    endtask

    task automatic t_underflow();
        logic [W-1:0] v;
        pop_req = 1; #1;
        check("R6 unf_trap", W'(unf_trap), 1);
        step();
        check("R6 depth", W'(depth), 1);
        rd(6, v); check("R6 r6 untouched", v, 32'h66);
    endtask

    task automatic t_overflow();
        logic [W-1:0] v;
        for (int i = 1; i < 4; i++) begin
            push_req = 1; wr_en = 1; wr_idx = 6; wr_data = 32'hA0 + W'(i); #1;
            check("R3 no ovf below full", W'(ovf_trap), 0);
            step();
        end
        check("R3 depth full", W'(depth), LV);
        rd(6, v); check("R11 write lands in new top", v, 32'hA3);
        check("R9 spill shows oldest r6", spill_data[0 +: W], 32'h66);
        check("R9 spill slot of ret", spill_data[RA_SLOT*W +: W], 0);
        push_req = 1; #1;
        check("R4 ovf_trap", W'(ovf_trap), 1);
        step();
        check("R4 depth unchanged", W'(depth), LV);
        rd(6, v); check("R4 top unchanged", v, 32'hA3);
    endtask

    task automatic t_spill_fill();
        spill_req = 1; step();
        check("R9 depth after spill", W'(depth), 3);
        check("R9 spill next level", spill_data[0 +: W], 32'hA1);
        spill_req = 1; fill_req = 1; step();
        check("R12 spill beats fill", W'(depth), 2);
        fill_data = '0; fill_data[0 +: W] = 32'hBB; fill_req = 1; step();
        check("R10 depth after fill", W'(depth), 3);
        check("R10 filled value", spill_data[0 +: W], 32'hBB);
    endtask

    task automatic t_mask();
        logic [W-1:0] v;
        pop_req = 1; step();
        rd(6, v); check("R5 pop to A2", v, 32'hA2);
        wr_en = 1; wr_idx = 7; wr_data = 32'h77; step();
        rmask_we = 1; rmask_data = 9'b0_0000_0001; step();
        pop_req = 1; step();
        check("R7 depth", W'(depth), 1);
        rd(6, v); check("R7 masked r6 kept", v, 32'hA2);
        rd(7, v); check("R7 unmasked r7 restored", v, 0);
    endtask

    task automatic t_priority();
        push_req = 1; pop_req = 1; #1;
        check("R12 no unf with push", W'(unf_trap), 0);
        step();
        check("R12 push beats pop", W'(depth), 2);
        fill_req = 1; step(); fill_req = 1; step(); fill_req = 1; step();
        check("R12 fill ignored at full", W'(depth), LV);
    endtask

    initial begin
        fork
            begin
                #1000000;
                failures++; checks++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        join_none
        idle();
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
        call_addr = 0; rmask_data = 0; fill_data = '0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1; rst = 0;
        t_reset();
        t_globals();
        t_push_pop();
        t_underflow();
        t_overflow();
        t_spill_fill();
        t_mask();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule